// File: doc/BRIEF.md
# Dual-Edge Pulse Width Capture Timer

A 16-bit up-counter runs freely on a prescaled count clock. One external input pin is watched through a two-sample glitch filter that runs on the same count clock. The programmed valid edge copies the counter into capture register 1 and raises a one-cycle interrupt. The opposite edge copies the counter into capture register 0. Software reads both registers. For a pulse that begins on the valid edge, the pulse width in count-clock ticks is capture 0 minus capture 1, modulo 2^16.

Three small registers configure the block through a write port. The run field either stops the counter at zero or lets it run. The capture-control field either enables the measurement or disables it. The prescale register holds the count-clock divisor and the edge choice. A counter wrap sets a sticky overflow flag and pulses an overflow interrupt. Software clears the flag with a write, and this lets it extend a measurement that spans a wrap.

Top module: `pulse_span_timer`

## Requirements
- R1: After reset the counter, both capture registers, the overflow flag and both interrupt outputs are zero, the run field is stopped (00), capture control is off (000), and the prescale register selects divide-by-1 with the falling valid edge.
- R2: The run field is bits [1:0] at address 0. While it is 00 the counter is held at zero and the filter history is cleared. The value 01 makes the counter run.
- R3: Bits [1:0] at address 2 choose the count clock: 00 gives one tick per clock, 01 gives one tick every 4 clocks, 10 gives one tick every 16 clocks. While running, the counter advances by exactly one on each tick and by nothing between ticks.
- R4: Bits [3:2] at address 2 choose the valid edge: 00 is falling, 01 is rising, 11 is both. On a valid edge the counter value is loaded into capture 1, and `cap_irq_o` pulses for one cycle.
- R5: With a single valid edge selected, the opposite edge loads the counter into capture 0. For an input pulse that is N ticks long (N ≥ 2), capture 0 minus capture 1 equals N.
- R6: With both edges selected, every accepted edge loads capture 1 and pulses `cap_irq_o`, and capture 0 keeps its value.
- R7: A new input level is accepted only after it has been seen on two consecutive ticks. A pulse that is seen on only one tick loads no register and raises no interrupt.
- R8: Bits [2:0] at address 1 control capture: 111 enables both capture registers, and 000 disables all captures and the capture interrupt.
- R9: When the counter wraps from all ones to zero, `ovf_o` is set and `ovf_irq_o` pulses once. A legal write to address 0 with bit 7 set clears `ovf_o`. A wrap in the same cycle takes priority over the clear.
- R10: A write that carries an illegal value is ignored as a whole, and the previous settings are kept. The illegal values are run field 10 or 11, count-clock select 11, edge select 10, and any capture-control value other than 000 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 run, 1 capture control, 2 prescale |
| wr_data_i | input | 8 | Register write data |
| cap_pin_i | input | 1 | Measured input pin |
| count_o | output | 16 | Current counter value |
| cap0_o | output | 16 | Capture register 0 (opposite edge) |
| cap1_o | output | 16 | Capture register 1 (valid edge) |
| ovf_o | output | 1 | Sticky overflow flag |
| cap_irq_o | output | 1 | One-cycle pulse on a valid-edge capture |
| ovf_irq_o | output | 1 | One-cycle pulse on counter wrap |

## Verification
The assertions check the following on every cycle:
- that the counter holds between ticks and sits at zero while stopped;
- that an accepted edge follows a tick and that a level seen on one tick yields no edge;
- that capture registers load the counter value of the cycle before;
- that a wrap sets the flag;
- that capture 0 stays still in both-edge mode;
- that an illegal prescale write leaves the edge choice unchanged.

Only the bench scenarios can show that whole pulses of known length give the right width for every divisor and edge choice, and that a one-tick glitch is filtered. The same holds for the behaviour of rejected writes seen at the pins and for clearing the overflow flag by software.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_RUN  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CAPC = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRE  = 2'd2;

  localparam logic [2:0] CAPC_OFF  = 3'b000;
  localparam logic [2:0] CAPC_MEAS = 3'b111;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    DIV1  = 2'b00,
    DIV4  = 2'b01,
    DIV16 = 2'b10
  } clk_sel_e;
endpackage

// File: rtl/pst_prescaler.sv
module pst_prescaler
  import pst_pkg::*;
#(
  parameter int MID_LOG = 2,
  parameter int TOP_LOG = 4
) (
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     clr_i,
  input  clk_sel_e sel_i,
  output logic     tick_o
);
  logic [TOP_LOG-1:0] div_q;
  logic [TOP_LOG-1:0] mask;

  always_comb begin
    case (sel_i)
      DIV4:    mask = TOP_LOG'((1 << MID_LOG) - 1);
      DIV16:   mask = '1;
      default: mask = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q & mask) == mask;

  // R3
  slow_tick_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i == DIV16 && tick_o) |=> (!tick_o || sel_i != DIV16));
endmodule

// File: rtl/pst_edge_filter.sv
module pst_edge_filter (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic tick_i,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic samp_q;
  logic lvl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      samp_q <= 1'b0;
      lvl_q  <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (tick_i) begin
        samp_q <= pin_i;
        if (pin_i == samp_q && pin_i != lvl_q) begin
          lvl_q  <= pin_i;
          rise_o <= pin_i;
          fall_o <= ~pin_i;
        end
      end
    end
  end

  // R7
  edge_after_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_o || fall_o) |-> $past(tick_i));
  // R7
  single_sample_reject_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !clr_i && pin_i != samp_q) |=> !(rise_o || fall_o));
  // R7
  edge_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/pst_free_counter.sv
module pst_free_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             ovf_irq_o
);
  logic wrap;
  assign wrap = run_i && tick_i && (count_o == '1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_o   <= '0;
      ovf_o     <= 1'b0;
      ovf_irq_o <= 1'b0;
    end else begin
      ovf_irq_o <= wrap;
      if (!run_i)      count_o <= '0;
      else if (tick_i) count_o <= count_o + 1'b1;
      if (ovf_clr_i) ovf_o <= 1'b0;
      if (wrap)      ovf_o <= 1'b1;
    end
  end

  // R2
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> (count_o == '0));
  // R3
  idle_between_ticks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && !tick_i) |=> $stable(count_o));
  // R9
  wrap_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && tick_i && count_o == '1) |=> (ovf_o && ovf_irq_o && count_o == '0));
endmodule

// File: rtl/pulse_span_timer.sv
module pulse_span_timer
  import pst_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MID_LOG = 2,
  parameter int TOP_LOG = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              cap_pin_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cap0_o,
  output logic [CNT_W-1:0]  cap1_o,
  output logic              ovf_o,
  output logic              cap_irq_o,
  output logic              ovf_irq_o
);
  logic      run_q;
  logic [2:0] capc_q;
  edge_sel_e es_q;
  clk_sel_e  cs_q;

  logic run_wr, capc_wr, pre_wr, ovf_clr;
  logic tick, rise, fall;
  logic cap_on, valid_hit, inv_hit;
  logic unused_bits;

  assign unused_bits = ^wr_data_i[6:4];

  assign run_wr  = wr_en_i && wr_addr_i == A_RUN && !wr_data_i[1];
  assign capc_wr = wr_en_i && wr_addr_i == A_CAPC &&
                   (wr_data_i[2:0] == CAPC_OFF || wr_data_i[2:0] == CAPC_MEAS);
  assign pre_wr  = wr_en_i && wr_addr_i == A_PRE &&
                   wr_data_i[1:0] != 2'b11 && wr_data_i[3:2] != 2'b10;
  assign ovf_clr = run_wr && wr_data_i[7];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q  <= 1'b0;
      capc_q <= CAPC_OFF;
      es_q   <= EDGE_FALL;
      cs_q   <= DIV1;
    end else begin
      if (run_wr)  run_q  <= wr_data_i[0];
      if (capc_wr) capc_q <= wr_data_i[2:0];
      if (pre_wr) begin
        cs_q <= clk_sel_e'(wr_data_i[1:0]);
        es_q <= edge_sel_e'(wr_data_i[3:2]);
      end
    end
  end

  pst_prescaler #(.MID_LOG(MID_LOG), .TOP_LOG(TOP_LOG)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(!run_q), .sel_i(cs_q), .tick_o(tick)
  );

  pst_edge_filter u_filt (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(!run_q), .tick_i(tick),
    .pin_i(cap_pin_i), .rise_o(rise), .fall_o(fall)
  );

  pst_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run_q), .tick_i(tick),
    .ovf_clr_i(ovf_clr), .count_o(count_o), .ovf_o(ovf_o), .ovf_irq_o(ovf_irq_o)
  );

  assign cap_on = run_q && capc_q == CAPC_MEAS;

  always_comb begin
    case (es_q)
      EDGE_RISE: begin valid_hit = rise;        inv_hit = fall; end
      EDGE_BOTH: begin valid_hit = rise | fall; inv_hit = 1'b0; end
      default:   begin valid_hit = fall;        inv_hit = rise; end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cap0_o    <= '0;
      cap1_o    <= '0;
      cap_irq_o <= 1'b0;
    end else begin
      cap_irq_o <= cap_on && valid_hit;
      if (cap_on && valid_hit) cap1_o <= count_o;
      if (cap_on && inv_hit)   cap0_o <= count_o;
    end
  end

  // R4
  valid_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cap_on && valid_hit) |=> (cap_irq_o && cap1_o == $past(count_o)));
  // R5
  inverse_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cap_on && inv_hit) |=> (cap0_o == $past(count_o)));
  // R6
  both_keeps_cap0_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (es_q == EDGE_BOTH) |=> $stable(cap0_o));
  // R8
  capture_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (capc_q == CAPC_OFF) |=> (!cap_irq_o && $stable(cap1_o)));
  // R10
  bad_edge_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == A_PRE && wr_data_i[3:2] == 2'b10) |=> $stable(es_q));
endmodule

// File: tb/pulse_span_timer_bench.sv
module pulse_span_timer_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          pin = 1'b0;
  logic [CW-1:0] cnt, cap0, cap1;
  logic          ovf, cap_irq, ovf_irq;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_span_timer #(.CNT_W(CW)) u_pulse_span_timer (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cap_pin_i(pin), .count_o(cnt), .cap0_o(cap0),
    .cap1_o(cap1), .ovf_o(ovf), .cap_irq_o(cap_irq), .ovf_irq_o(ovf_irq)
  );

  always @(posedge clk) begin
    #5;
    if (!rst && cap_irq) irq_seen++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int div_of(input logic [1:0] sel);
    return (sel == 2'd0) ? 1 : (sel == 2'd1) ? 4 : 16;
  endfunction

  task automatic setup(input logic [1:0] sel, input logic [1:0] es, input logic idle);
    wr(2'd0, 8'h00);
    wr(2'd2, {4'b0, es, sel});
    wr(2'd1, 8'h07);
    pin = idle;
    wr(2'd0, 8'h01);
    cycles(6 * div_of(sel) + 4);
  endtask

  task automatic measure(input logic [1:0] sel, input logic [1:0] es, input int n);
    int d, base;
    logic idle;
    logic [CW-1:0] c0;
    d = div_of(sel);
    idle = (es == 2'b00);
    setup(sel, es, idle);
    base = irq_seen;
    c0 = cap0;
    pin = ~idle;
    cycles(n * d);
    pin = idle;
    cycles(6 * d + 4);
    if (es == 2'b11) begin
      check("R6 irq count both edges", irq_seen - base, 2);
      check("R6 cap0 kept", cap0, c0);
    end else begin
      check("R4 one valid-edge irq", irq_seen - base, 1);
      check("R5 width cap0-cap1", CW'(cap0 - cap1), n);
    end
  endtask

  task automatic glitch(input logic [1:0] sel, input logic [1:0] es);
    int d, base;
    logic idle;
    logic [CW-1:0] c0, c1;
    d = div_of(sel);
    idle = (es == 2'b00);
    setup(sel, es, idle);
    base = irq_seen; c0 = cap0; c1 = cap1;
    pin = ~idle;
    cycles(d);
    pin = idle;
    cycles(6 * d + 4);
    check("R7 glitch no irq", irq_seen - base, 0);
    check("R7 glitch cap0 kept", cap0, c0);
    check("R7 glitch cap1 kept", cap1, c1);
  endtask

  task automatic rate(input logic [1:0] sel, input string req);
    logic [CW-1:0] a;
    a = cnt;
    cycles(4 * div_of(sel));
    check(req, CW'(cnt - a), 4);
  endtask

  initial begin
    logic [1:0] es_list [3];
    int n_list [3];
    int guard;
    es_list = '{2'b00, 2'b01, 2'b11};
    n_list  = '{2, 3, 7};
    cycles(5);
    rst = 1'b0;
    cycles(1);
    // R1 reset state
    check("R1 count", cnt, 0);
    check("R1 cap0", cap0, 0);
    check("R1 cap1", cap1, 0);
    check("R1 flags", {ovf, cap_irq, ovf_irq}, 0);
    cycles(10);
    check("R1 R2 stopped after reset", cnt, 0);

    // R3 rate sweep
    for (int s = 0; s < 3; s++) begin
      wr(2'd0, 8'h00);
      wr(2'd2, {6'b0, 2'(s)});
      wr(2'd0, 8'h01);
      rate(2'(s), "R3 ticks per window");
    end
    // R10 illegal select 11 ignored (still divide by 16)
    wr(2'd2, 8'h03);
    rate(2'd2, "R10 clk select 11 ignored");
    // R10 illegal run 10 ignored, counter keeps going
    wr(2'd0, 8'h02);
    rate(2'd2, "R10 run field 10 ignored");
    // R2 stop clears and holds
    wr(2'd0, 8'h00);
    cycles(2);
    check("R2 stop clears", cnt, 0);
    cycles(40);
    check("R2 stop holds", cnt, 0);

    // R4 R5 R6 sweep over divisor, edge and width
    for (int s = 0; s < 3; s++)
      for (int e = 0; e < 3; e++) begin
        for (int k = 0; k < 3; k++) measure(2'(s), es_list[e], n_list[k]);
        glitch(2'(s), es_list[e]);
      end

    // R10 edge select 10 ignored: rising stays in force
    setup(2'd0, 2'b01, 1'b0);
    wr(2'd2, 8'h08);
    begin
      int base;
      base = irq_seen;
      pin = 1'b1; cycles(4); pin = 1'b0; cycles(8);
      check("R10 edge 10 ignored irq", irq_seen - base, 1);
      check("R10 edge 10 ignored width", CW'(cap0 - cap1), 4);
    end

    // R8 capture off, then illegal control value ignored
    wr(2'd1, 8'h00);
    begin
      int base;
      logic [CW-1:0] c0, c1;
      base = irq_seen; c0 = cap0; c1 = cap1;
      pin = 1'b1; cycles(5); pin = 1'b0; cycles(8);
      check("R8 off no irq", irq_seen - base, 0);
      check("R8 off cap1 kept", cap1, c1);
      check("R8 off cap0 kept", cap0, c0);
      wr(2'd1, 8'h05);
      pin = 1'b1; cycles(5); pin = 1'b0; cycles(8);
      check("R10 R8 control 101 ignored", irq_seen - base, 0);
    end

    // R9 overflow
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    guard = 0;
    while (cnt != 16'hFFFE && guard < 70000) begin
      cycles(1);
      guard++;
    end
    check("R9 reached FFFE", cnt, 16'hFFFE);
    check("R9 no flag before wrap", ovf, 0);
    cycles(2);
    check("R9 wrapped to zero", cnt, 0);
    check("R9 flag set", ovf, 1);
    check("R9 irq pulse", ovf_irq, 1);
    cycles(1);
    check("R9 irq one cycle", ovf_irq, 0);
    check("R9 flag sticky", ovf, 1);
    wr(2'd0, 8'h81);
    check("R9 flag cleared", ovf, 0);
    check("R9 still running", cnt != 0, 1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule